// File: doc/BRIEF.md
# CRC-checked register frame engine

This block sits on the target side of an I2C-style byte link, above an existing byte layer that handles bit timing, acknowledge and clock stretching. The byte layer reports every start condition (repeated starts included) together with the 7-bit target address and the direction bit. It then delivers the bytes the host writes and asks for each byte the host reads. Behind the engine sits a 64-byte register array.

Every frame is protected by a CRC-8 with polynomial 0x07. The CRC is computed MSB first, starts at zero and has no final XOR. Its input starts with the 8-bit bus address byte `{addr, rw}` and then takes the command byte and the data bytes. The command byte holds the starting register index in bits [5:0] and a transfer length of 1 to 4 bytes in bits [7:6].

A write frame carries the command byte, the data bytes, a CRC byte and a trailing dummy byte. The data bytes are staged and reach the array only when the CRC matches and the dummy byte has arrived. For a read, the host first sets the command byte with a short write frame. It then sends a repeated start with R/W=1 and clocks out the data bytes followed by their CRC.

Top module: `crc_frame_engine`

## Requirements
- R1: After reset every output is 0, all 64 registers hold 0x00, and the command byte is 0x00 (index 0, one byte).
- R2: Every CRC is CRC-8 with polynomial 0x07, processed MSB first, starting at 0x00 with no final XOR. It covers the byte `{tgt_addr, rw}` (rw=0 for write, 1 for read), then the command byte, then the data bytes. The CRC state restarts at every start condition.
- R3: The command byte gives the first register index in bits [5:0] and the length in bits [7:6]: 00=1, 01=2, 10=3, 11=4 bytes.
- R4: In a write frame the bytes arrive in this order: command, N data bytes, CRC, dummy. When the CRC matches, the data goes to consecutive indices from the command index, wrapping modulo 64, once the dummy byte arrives. The frame end then pulses `done` for one cycle.
- R5: A complete write frame whose CRC byte mismatches changes no register. Its frame end pulses `err` for one cycle and sets `crc_err`.
- R6: A write frame that ends after the first data byte but before the dummy byte changes no register. It pulses `err` and leaves `crc_err` unchanged.
- R7: A write frame that carries only the command byte changes no register. It sets the command used by following reads and pulses `done`.
- R8: In a read frame, the first N `tx_req` requests return the registers from the command index upward, wrapping modulo 64. The next request returns the CRC over `{tgt_addr,1}`, the command byte and those data bytes. Any further request returns 0xFF.
- R9: A read frame ends with a `done` pulse if the CRC byte was delivered, and with an `err` pulse otherwise.
- R10: A start condition while a frame is open ends that frame and reports it in the same way a stop condition does.
- R11: `tx_valid` pulses exactly one cycle after a `tx_req` in a read frame. `tx_req` in a write frame gives no `tx_valid`. `rx_valid` bytes in a read frame change nothing.
- R12: Once set, `crc_err` stays set until reset.
- R13: Bytes that follow the dummy byte of a write frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start or repeated-start pulse; qualifies tgt_addr and rw |
| tgt_addr | input | 7 | 7-bit target address of the frame |
| rw | input | 1 | Direction: 0 write, 1 read |
| rx_valid | input | 1 | Host byte available on rx_byte |
| rx_byte | input | 8 | Byte written by the host |
| tx_req | input | 1 | Byte layer requests the next read byte |
| stop | input | 1 | Stop condition pulse |
| tx_byte | output | 8 | Byte for the host, valid with tx_valid |
| tx_valid | output | 1 | tx_byte valid, one cycle after tx_req |
| done | output | 1 | One-cycle pulse: frame completed correctly |
| err | output | 1 | One-cycle pulse: frame was short or failed its CRC |
| crc_err | output | 1 | Sticky write-CRC mismatch flag |

## Verification
Random frames use random addresses, indices, lengths and data, and each is read back through a repeated start. The random addresses show that the CRC covers the address byte and the direction bit. The random lengths and indices separate the length decode from the index decode and exercise the wrap across index 63. Directed frames corrupt the CRC, stop before the dummy byte, append extra bytes after the dummy byte, and cut a read short. Together these tell apart a commit on CRC alone, a commit before the dummy byte, and correct discarding. Crossed-direction traffic shows that stray bytes and requests in the wrong frame type leave the state untouched.

// File: rtl/crc_frame_engine.sv
module crc_frame_engine (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [6:0] tgt_addr,
  input  logic       rw,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       tx_req,
  input  logic       stop,
  output logic [7:0] tx_byte,
  output logic       tx_valid,
  output logic       done,
  output logic       err,
  output logic       crc_err
);
  localparam int IDX_W = 6;
  localparam int NREGS = 1 << IDX_W;
  localparam int MAXB  = 4;

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] x;
    x = c ^ b;
    for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  logic [7:0] regs [NREGS];
  logic [7:0] stage [MAXB];
  logic [7:0] cmd, crc_r;
  logic [2:0] cnt;
  logic       active, rd, crc_ok;

  wire [2:0]       len    = {1'b0, cmd[7:6]} + 3'd1;
  wire [IDX_W-1:0] base   = cmd[IDX_W-1:0];
  wire             end_ev = active & (stop | start);
  wire             wr_rx  = active & ~rd & rx_valid;
  wire             rd_tx  = active & rd & tx_req;
  wire             commit = wr_rx & (cnt == len + 3'd2) & crc_ok;
  wire             wr_cmp = cnt >= len + 3'd3;
  wire [IDX_W-1:0] rd_idx = base + IDX_W'(cnt);

  wire end_good = rd ? (cnt > len) : (cnt <= 3'd1 || (wr_cmp && crc_ok));
  wire end_bad_crc = ~rd & wr_cmp & ~crc_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      rd <= 1'b0;
      cnt <= '0;
      cmd <= '0;
      crc_r <= '0;
      crc_ok <= 1'b0;
      tx_byte <= '0;
      tx_valid <= 1'b0;
      done <= 1'b0;
      err <= 1'b0;
      crc_err <= 1'b0;
      for (int k = 0; k < MAXB; k++) stage[k] <= '0;
    end else begin
      tx_valid <= 1'b0;
      done <= end_ev & end_good;
      err <= end_ev & ~end_good;
      if (end_ev & end_bad_crc) crc_err <= 1'b1;

      if (start) begin
        active <= 1'b1;
        rd <= rw;
        cnt <= '0;
        crc_ok <= 1'b0;
        crc_r <= rw ? crc_step(crc_step(8'h00, {tgt_addr, 1'b1}), cmd)
                    : crc_step(8'h00, {tgt_addr, 1'b0});
      end else if (stop) begin
        active <= 1'b0;
      end else if (wr_rx) begin
        if (cnt != 3'd7) cnt <= cnt + 3'd1;
        if (cnt == 3'd0) begin
          cmd <= rx_byte;
          crc_r <= crc_step(crc_r, rx_byte);
        end else if (cnt <= len) begin
          stage[cnt - 3'd1] <= rx_byte;
          crc_r <= crc_step(crc_r, rx_byte);
        end else if (cnt == len + 3'd1) begin
          crc_ok <= (rx_byte == crc_r);
        end
      end else if (rd_tx) begin
        tx_valid <= 1'b1;
        if (cnt != 3'd7) cnt <= cnt + 3'd1;
        if (cnt < len) begin
          tx_byte <= regs[rd_idx];
          crc_r <= crc_step(crc_r, regs[rd_idx]);
        end else if (cnt == len) begin
          tx_byte <= crc_r;
        end else begin
          tx_byte <= 8'hFF;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (commit) begin
      for (int k = 0; k < MAXB; k++)
        if (3'(k) < len) regs[base + IDX_W'(k)] <= stage[k];
    end
  end
endmodule

// File: rtl/crc_frame_engine_chk.sv
module crc_frame_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic stop,
  input logic tx_req,
  input logic tx_valid,
  input logic done,
  input logic err,
  input logic crc_err
);
  // R9
  frame_end_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err}));

  // R10
  end_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> $past(start || stop));

  // R11
  tx_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(tx_req));

  // R12
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(crc_err) |-> crc_err);

  // R5
  sticky_with_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_err) |-> err);
endmodule

bind crc_frame_engine crc_frame_engine_chk u_chk (.*);

// File: tb/crc_frame_engine_test.sv
module crc_frame_engine_test;
  logic clk = 0, rst_n = 0, start = 0, rw = 0, rx_valid = 0, tx_req = 0, stop = 0;
  logic [6:0] tgt_addr = '0;
  logic [7:0] rx_byte = '0;
  logic [7:0] tx_byte;
  logic tx_valid, done, err, crc_err;
  int checks = 0, errors = 0;
  logic [7:0] model [64];
  logic [7:0] cur_cmd;

  always #5 clk = ~clk;

  crc_frame_engine uut (.*);

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] x;
    x = c ^ b;
    for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_start(input logic [6:0] a, input logic r, output logic dn, output logic er);
    @(negedge clk);
    start = 1; tgt_addr = a; rw = r;
    @(negedge clk);
    dn = done; er = err; start = 0;
  endtask

  task automatic do_stop(output logic dn, output logic er);
    @(negedge clk);
    stop = 1;
    @(negedge clk);
    dn = done; er = err; stop = 0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_byte = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic pull(output logic [7:0] b, output logic v);
    @(negedge clk);
    tx_req = 1;
    @(negedge clk);
    b = tx_byte; v = tx_valid; tx_req = 0;
  endtask

  // mode 0 good, 1 bad crc, 2 stop before dummy
  task automatic wr_frame(input logic [6:0] a, input logic [7:0] c, input logic [31:0] d,
                          input int mode, input int extra, output logic dn, output logic er);
    logic [7:0] crc;
    logic x1, x2;
    int n;
    n = int'(c[7:6]) + 1;
    do_start(a, 1'b0, x1, x2);
    crc = crc_step(8'h00, {a, 1'b0});
    send(c); crc = crc_step(crc, c);
    for (int k = 0; k < n; k++) begin
      send(d[8*k +: 8]); crc = crc_step(crc, d[8*k +: 8]);
    end
    send(mode == 1 ? crc ^ 8'h5A : crc);
    if (mode != 2) send(8'hA5);
    for (int k = 0; k < extra; k++) send(8'(($urandom)));
    do_stop(dn, er);
    cur_cmd = c;
    if (mode == 0)
      for (int k = 0; k < n; k++) model[(int'(c[5:0]) + k) % 64] = d[8*k +: 8];
  endtask

  // set command, repeated start, read n bytes + crc, check all
  task automatic rd_check(input string tag, input logic [6:0] a, input logic [7:0] c);
    logic [7:0] crc, b;
    logic v, dn, er;
    int n;
    n = int'(c[7:6]) + 1;
    do_start(a, 1'b0, dn, er);
    send(c);
    do_start(a, 1'b1, dn, er);
    chk({tag, " R7 R10 cmd-only frame done"}, {30'd0, dn, er}, 32'b10);
    cur_cmd = c;
    crc = crc_step(crc_step(8'h00, {a, 1'b1}), c);
    for (int k = 0; k < n; k++) begin
      pull(b, v);
      chk({tag, " R8 R3 data"}, {23'd0, v, b}, {23'd0, 1'b1, model[(int'(c[5:0]) + k) % 64]});
      crc = crc_step(crc, model[(int'(c[5:0]) + k) % 64]);
    end
    pull(b, v);
    chk({tag, " R2 R8 read crc"}, {24'd0, b}, {24'd0, crc});
    do_stop(dn, er);
    chk({tag, " R9 read done"}, {30'd0, dn, er}, 32'b10);
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic dn, er, v;
    logic [7:0] b, crc;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    cur_cmd = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 outputs after reset", {tx_byte, tx_valid, done, err, crc_err}, 12'h0);

    // R1: default command reads register 0 without prior command
    do_start(7'h34, 1'b1, dn, er);
    pull(b, v);
    chk("R1 reset register value", {23'd0, v, b}, {23'd0, 1'b1, 8'h00});
    pull(b, v);
    crc = crc_step(crc_step(crc_step(8'h00, {7'h34, 1'b1}), 8'h00), 8'h00);
    chk("R1 R2 reset read crc", {24'd0, b}, {24'd0, crc});
    pull(b, v);
    chk("R8 filler after crc", {24'd0, b}, 32'hFF);
    do_stop(dn, er);
    chk("R9 read done", {30'd0, dn, er}, 32'b10);

    // R4 wrap at 63
    wr_frame(7'h1A, 8'hC0 | 8'd62, 32'h44332211, 0, 0, dn, er);
    chk("R4 good write done", {30'd0, dn, er}, 32'b10);
    rd_check("R4 wrap readback", 7'h1A, 8'hC0 | 8'd62);

    // R5 bad crc
    wr_frame(7'h1A, 8'h40 | 8'd10, 32'h0000BEEF, 1, 0, dn, er);
    chk("R5 bad crc err pulse", {29'd0, dn, er, crc_err}, 32'b011);
    rd_check("R5 bad crc no change", 7'h1A, 8'h40 | 8'd10);

    // R6 stop before dummy
    wr_frame(7'h22, 8'h80 | 8'd20, 32'h00C0FFEE, 2, 0, dn, er);
    chk("R6 early stop err", {30'd0, dn, er}, 32'b01);
    rd_check("R6 early stop no change", 7'h22, 8'h80 | 8'd20);

    // R6 stop after first data byte
    do_start(7'h22, 1'b0, dn, er);
    send(8'h40 | 8'd30); send(8'h77);
    do_stop(dn, er);
    chk("R6 stop mid data err", {30'd0, dn, er}, 32'b01);
    rd_check("R6 mid data no change", 7'h22, 8'h40 | 8'd30);

    // R13 extra bytes after dummy
    wr_frame(7'h05, 8'd5, 32'h0000005C, 0, 3, dn, er);
    chk("R13 extra bytes still done", {30'd0, dn, er}, 32'b10);
    rd_check("R13 neighbours untouched", 7'h05, 8'h40 | 8'd5);

    // R11 tx_req in write frame, rx in read frame
    do_start(7'h11, 1'b0, dn, er);
    pull(b, v);
    chk("R11 no tx_valid in write frame", {31'd0, v}, 32'd0);
    do_stop(dn, er);
    cur_cmd = 8'h00;
    chk("R7 empty write frame done", {30'd0, dn, er}, 32'b10);
    do_start(7'h11, 1'b0, dn, er);
    send(8'hC0 | 8'd8);
    do_start(7'h11, 1'b1, dn, er);
    send(8'h99); send(8'h98); send(8'h97);
    crc = crc_step(crc_step(8'h00, {7'h11, 1'b1}), 8'hC8);
    for (int k = 0; k < 4; k++) begin
      pull(b, v);
      chk("R11 rx in read frame ignored", {24'd0, b}, {24'd0, model[8 + k]});
      crc = crc_step(crc, model[8 + k]);
    end
    // R9 read cut before crc
    do_stop(dn, er);
    chk("R9 short read err", {30'd0, dn, er}, 32'b01);
    rd_check("R11 registers unchanged", 7'h11, 8'hC0 | 8'd8);
    chk("R12 sticky still set", {31'd0, crc_err}, 32'd1);

    // random traffic
    for (int it = 0; it < 40; it++) begin
      logic [6:0] a;
      logic [7:0] c;
      logic [31:0] d;
      a = 7'($urandom);
      c = 8'($urandom);
      d = $urandom;
      wr_frame(a, c, d, 0, 0, dn, er);
      chk("R4 random write done", {30'd0, dn, er}, 32'b10);
      rd_check("R2 R3 random readback", 7'($urandom), c);
    end
    chk("R12 sticky at end", {31'd0, crc_err}, 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule